// File: doc/BRIEF.md
# Arithmetic-logic unit with condition-code register

This block performs the four register-to-register integer operations of a small 32-bit processor: addition, subtraction, bitwise AND and bitwise exclusive-OR, chosen by a two-bit function code. The result is combinational. When the execute stage marks the current operation as an arithmetic/logic instruction by raising `set_flags`, the block records three condition flags on the next rising clock edge. The flags are zero, sign and signed overflow. All other instruction kinds (moves, jumps, stack traffic) leave `set_flags` low, so the flags keep their values.

The same block decides conditional jumps. A three-bit branch code selects one of seven conditions, and the condition is evaluated against the flags already held in the register. The flags being produced by an operation in the same cycle are not used. Writing the result to a register and steering the program counter are the job of the surrounding pipeline. Operands, codes and strobe are plain control/data pins with no handshake, because the block holds no data beyond its three flag bits.

Top module: `yalu_cc_unit`

## Requirements
- R1: `op_fn` selects the result combinationally: 0 gives `opnd_b + opnd_a`, 1 gives `opnd_b - opnd_a`, 2 gives `opnd_a & opnd_b`, 3 gives `opnd_a ^ opnd_b`, all modulo 2^32.
- R2: Subtraction takes the first operand (`opnd_a`, the source register) away from the second (`opnd_b`, the destination register), never the reverse.
- R3: On a rising edge with `set_flags` high, `flag_z` becomes 1 exactly when the result is zero and `flag_s` becomes bit 31 of the result. This includes AND of a value with itself, which is used as a test.
- R4: On such an edge `flag_o` records signed overflow. For add it is set when both operands have the same sign and the result's sign differs from theirs. For subtract it is set when `opnd_b` and `opnd_a` differ in sign and the result's sign differs from `opnd_b`.
- R5: On such an edge, AND and XOR always clear `flag_o`.
- R6: On a rising edge with `set_flags` low, all three flags keep their values, whatever the operands and `op_fn`.
- R7: A synchronous active-low reset sets `flag_z`=1, `flag_s`=0, `flag_o`=0.
- R8: `br_taken` is combinational from the stored flags. With lt = `flag_s` xor `flag_o` and le = lt or `flag_z`, `br_fn` 0 is always taken, 1 gives le, 2 gives lt, 3 gives `flag_z`, 4 gives not `flag_z`, 5 gives not lt and 6 gives not le. Code 7 is never taken.
- R9: `br_taken` in a cycle depends only on flags stored at earlier edges, not on the flags the operation in that same cycle would produce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 32 | Source operand (rA) |
| opnd_b | input | 32 | Destination operand (rB) |
| op_fn | input | 2 | Operation select |
| set_flags | input | 1 | Record flags at the next edge |
| br_fn | input | 3 | Branch condition select |
| result | output | 32 | Operation result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |
| br_taken | output | 1 | Selected branch condition holds |

## Verification
Random operand pairs drawn from full-range, sign-boundary and small-value pools exercise all four operations. Mostly the result is non-zero, and the pools make sure sign mixes of both kinds appear often. Directed cases add up to and subtract across the most positive and most negative values, which separates a correct overflow rule from one that looks only at the carry or uses the wrong subtraction order. A zero result from a self-AND and from an equal-operand subtract checks the zero flag apart from the sign flag. Each branch code is evaluated after flag sets that make lt and le differ, and is also evaluated in the same cycle as a flag-changing operation, which exposes any path from the new flags into `br_taken`.

// File: rtl/yalu_pkg.sv
package yalu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_ALWAYS = 3'd0,
    BR_LE     = 3'd1,
    BR_LT     = 3'd2,
    BR_EQ     = 3'd3,
    BR_NE     = 3'd4,
    BR_GE     = 3'd5,
    BR_GT     = 3'd6,
    BR_NEVER  = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_t;

  localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/yalu_arith.sv
module yalu_arith
  import yalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output cc_t          cc_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum_w;
  logic [W-1:0] diff_w;
  logic         ovf_add;
  logic         ovf_sub;

  assign sum_w   = b_i + a_i;
  assign diff_w  = b_i - a_i;
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != b_i[MSB]);

  always_comb begin
    res_o = '0;
    cc_o  = '0;
    unique case (op_i)
      OP_ADD: begin res_o = sum_w;     cc_o.of = ovf_add; end
      OP_SUB: begin res_o = diff_w;    cc_o.of = ovf_sub; end
      OP_AND: begin res_o = a_i & b_i; cc_o.of = 1'b0;    end
      OP_XOR: begin res_o = a_i ^ b_i; cc_o.of = 1'b0;    end
      default: begin res_o = '0;       cc_o.of = 1'b0;    end
    endcase
    cc_o.zf = (res_o == '0);
    cc_o.sf = res_o[MSB];
  end
endmodule

// File: rtl/yalu_ccreg.sv
module yalu_ccreg
  import yalu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cc_t  cc_i,
  output cc_t  cc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cc_o <= CC_RESET;
    else if (load_i) cc_o <= cc_i;
  end
endmodule

// File: rtl/yalu_brcond.sv
module yalu_brcond
  import yalu_pkg::*;
(
  input  cc_t      cc_i,
  input  br_cond_e fn_i,
  output logic     take_o
);
  logic lt_w;
  logic le_w;

  assign lt_w = cc_i.sf ^ cc_i.of;
  assign le_w = lt_w | cc_i.zf;

  always_comb begin
    unique case (fn_i)
      BR_ALWAYS: take_o = 1'b1;
      BR_LE:     take_o = le_w;
      BR_LT:     take_o = lt_w;
      BR_EQ:     take_o = cc_i.zf;
      BR_NE:     take_o = ~cc_i.zf;
      BR_GE:     take_o = ~lt_w;
      BR_GT:     take_o = ~le_w;
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/yalu_cc_unit.sv
module yalu_cc_unit
  import yalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   op_fn,
  input  logic         set_flags,
  input  logic [2:0]   br_fn,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_o,
  output logic         br_taken
);
  cc_t cc_next;
  cc_t cc_q;

  yalu_arith #(.W(W)) u_arith (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .op_i  (alu_op_e'(op_fn)),
    .res_o (result),
    .cc_o  (cc_next)
  );

  yalu_ccreg u_ccreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (set_flags),
    .cc_i   (cc_next),
    .cc_o   (cc_q)
  );

  yalu_brcond u_brcond (
    .cc_i   (cc_q),
    .fn_i   (br_cond_e'(br_fn)),
    .take_o (br_taken)
  );

  assign flag_z = cc_q.zf;
  assign flag_s = cc_q.sf;
  assign flag_o = cc_q.of;
endmodule

// File: rtl/yalu_cc_chk.sv
module yalu_cc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [1:0]   op_fn,
  input logic         set_flags,
  input logic [2:0]   br_fn,
  input logic [W-1:0] result,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_o,
  input logic         br_taken
);
  // R3: stored zero/sign track the result seen at the loading edge
  a_r3_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_z == ($past(result) == '0)) && (flag_s == $past(result[W-1])));

  // R4: add overflow recorded from operand and result signs
  a_r4_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_fn == 2'd0) |=>
      flag_o == $past((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])));

  // R5: logic operations clear overflow
  a_r5_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_fn[1]) |=> !flag_o);

  // R6: flags hold without the strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable({flag_z, flag_s, flag_o}));

  // R8: unconditional taken, code 7 never, equal follows zero flag
  a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn == 3'd0) |-> br_taken);
  a_r8_never: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn == 3'd7) |-> !br_taken);
  a_r8_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn == 3'd3) |-> (br_taken == flag_z));
endmodule

bind yalu_cc_unit yalu_cc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_fn     (op_fn),
  .set_flags (set_flags),
  .br_fn     (br_fn),
  .result    (result),
  .flag_z    (flag_z),
  .flag_s    (flag_s),
  .flag_o    (flag_o),
  .br_taken  (br_taken)
);

// File: tb/yalu_cc_unit_tb_top.sv
module yalu_cc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  op_fn = '0;
  logic        set_flags = 1'b0;
  logic [2:0]  br_fn = '0;
  logic [31:0] result;
  logic        flag_z, flag_s, flag_o, br_taken;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2:0] m_cc; // {z,s,o} bench model

  always #2 clk = ~clk;

  yalu_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_fn(op_fn), .set_flags(set_flags), .br_fn(br_fn),
    .result(result), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .br_taken(br_taken)
  );

  function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic [1:0] f);
    case (f)
      2'd0: return b + a;
      2'd1: return b - a;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic [1:0] f);
    logic [31:0] r;
    r = exp_res(a, b, f);
    case (f)
      2'd0: return (a[31] == b[31]) && (r[31] != a[31]);
      2'd1: return (a[31] != b[31]) && (r[31] != b[31]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_br(logic [2:0] cc, logic [2:0] f);
    logic lt, le;
    lt = cc[1] ^ cc[0];
    le = lt | cc[2];
    case (f)
      3'd0: return 1'b1;
      3'd1: return le;
      3'd2: return lt;
      3'd3: return cc[2];
      3'd4: return !cc[2];
      3'd5: return !lt;
      3'd6: return !le;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, then flags after the edge
  task automatic step(logic [31:0] a, logic [31:0] b, logic [1:0] f, logic sf, logic [2:0] bf);
    logic [31:0] r;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_fn = f; set_flags = sf; br_fn = bf;
    #1;
    r = exp_res(a, b, f);
    check((f == 2'd1) ? "R2 result" : "R1 result", result, r);
    check("R8/R9 br_taken", {31'd0, br_taken}, {31'd0, exp_br(m_cc, bf)});
    @(posedge clk);
    if (sf) m_cc = {(r == 32'd0), r[31], exp_ovf(a, b, f)};
    #1;
    check(sf ? "R3/R4/R5 flags" : "R6 flags held", {29'd0, flag_z, flag_s, flag_o}, {29'd0, m_cc});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 4)
      0: return $urandom;
      1: return 32'h8000_0000 + ($urandom % 4) - 2;
      2: return $urandom % 8;
      default: return 32'hFFFF_FFFF - ($urandom % 4);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    m_cc = 3'b100;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset flags", {29'd0, flag_z, flag_s, flag_o}, 32'd4);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: equal taken out of reset
    step(32'd5, 32'd9, 2'd0, 1'b0, 3'd3);
    // R4: positive add overflow
    step(32'd1, 32'h7FFF_FFFF, 2'd0, 1'b1, 3'd2);
    // R8: lt with s=1,o=1 is false; le false; gt true
    step(32'd0, 32'd0, 2'd2, 1'b0, 3'd2);
    step(32'd0, 32'd0, 2'd2, 1'b0, 3'd6);
    // R2/R4: 0x80000000 - 1 overflows; order matters
    step(32'd1, 32'h8000_0000, 2'd1, 1'b1, 3'd5);
    step(32'h8000_0000, 32'd1, 2'd1, 1'b1, 3'd1);
    // R3: self-AND test, zero and negative
    step(32'd0, 32'd0, 2'd2, 1'b1, 3'd4);
    step(32'hF000_0001, 32'hF000_0001, 2'd2, 1'b1, 3'd3);
    // R5: XOR clears overflow after an overflowing add
    step(32'd1, 32'h7FFF_FFFF, 2'd0, 1'b1, 3'd0);
    step(32'h1234_5678, 32'h1234_5678, 2'd3, 1'b1, 3'd4);
    // R6: overflowing subtract with strobe low leaves flags
    step(32'h8000_0000, 32'd1, 2'd1, 1'b0, 3'd7);
    // R9: same-cycle ops that would flip flags; branch uses stored ones
    for (int bf = 0; bf < 8; bf++) begin
      step(32'd3, 32'd3, 2'd1, 1'b1, 3'(bf));
      step(32'd1, 32'd0, 2'd1, 1'b1, 3'(bf));
      step(32'h8000_0000, 32'd1, 2'd1, 1'b1, 3'(bf));
    end
    // random mix across R1..R9
    for (int i = 0; i < 3000; i++)
      step(pick(), pick(), 2'($urandom), ($urandom % 4) != 0, 3'($urandom));

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule